// File: doc/BRIEF.md
# Clock gear and prescaler controller

This block builds the clock tree of a small controller out of single-cycle enable strobes on one reference clock. It takes three source strobes: the internal high-speed oscillator, the external high-speed oscillator, and a PLL output that runs at four times the oscillator rate. The PLL and the oscillators are modelled outside the block. A register picks the oscillator and decides whether the PLL output is used. The chosen strobe is the high-speed tick. A gear divider turns it into the system tick.

The peripheral tick is taken either from the system tick or straight from the high-speed tick. A second divider, the prescaler, divides it again to give the timer prescaler tick. Each divided output is a one-cycle pulse that lines up with the source strobe that ends its period. Downstream logic uses these pulses as clock enables, so no derived clock net exists.

Two registers are written through a plain write port. A ratio written to either divider is held as pending and takes effect only where the current period ends. A request for the PLL path while the PLL is not marked running is refused, and a sticky error flag records it. After reset the tree runs undivided from the internal oscillator.

Top module: `clkgear_ctrl`

## Requirements
- R1: After reset the following hold: the internal oscillator is selected, the PLL is bypassed, the gear and prescaler ratios are /1, the peripheral tick follows the system tick, and pll_err, ext_hs_on, lo_on and pll_on are all 0. In this state an int_tick pulse appears on all four tick outputs in the same cycle, and ext_tick and pll_tick have no effect.
- R2: Source register (wr_addr 0), bit 0 selects the oscillator: 0 means the internal one (int_tick) and 1 means the external one (ext_tick). The choice applies from the cycle after the write.
- R3: Source register bit 1 requests the PLL and bit 2 marks the PLL as running. When both are 1, hs_tick follows pll_tick. Otherwise hs_tick follows the selected oscillator.
- R4: A source-register write with bit 1 set and bit 2 clear sets pll_err from the next cycle. pll_err then stays 1 until reset, whatever is written later.
- R5: Divider register (wr_addr 1), bits 2:0 hold the gear code g, valid from 0 to 4. sys_tick pulses on every 2^g-th hs_tick, in the same cycle as that hs_tick.
- R6: A gear code of 5, 6 or 7 leaves the current gear ratio unchanged. The other fields of the same write still apply.
- R7: Divider register bit 3 selects the source of the peripheral tick: 0 means sys_tick and 1 means hs_tick. periph_tick is that strobe in the same cycle.
- R8: Divider register bits 6:4 hold the prescaler code p, valid from 0 to 5. presc_tick pulses on every 2^p-th periph_tick. A code of 6 or 7 leaves the prescaler ratio unchanged.
- R9: A new ratio for either divider takes effect only after the divider emits the pulse that ends its current period. A period already under way finishes at the old length.
- R10: ext_hs_on, lo_on and pll_on show source register bits 3, 4 and 2 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_tick | input | 1 | Internal high-speed oscillator strobe |
| ext_tick | input | 1 | External high-speed oscillator strobe |
| pll_tick | input | 1 | PLL output strobe (four times the oscillator rate) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 source, 1 divider |
| wr_data | input | 8 | Write data |
| hs_tick | output | 1 | Selected high-speed tick |
| sys_tick | output | 1 | Gear-divided system tick |
| periph_tick | output | 1 | Peripheral tick |
| presc_tick | output | 1 | Prescaler-divided timer tick |
| ext_hs_on | output | 1 | External high-speed oscillator run flag |
| lo_on | output | 1 | Low-speed oscillator run flag |
| pll_on | output | 1 | PLL run flag |
| pll_err | output | 1 | Sticky refused-PLL-request flag |

## Verification
Two things can happen on the same clock edge: a ratio write that lands on a divider's period-ending pulse, and the gear boundary together with the prescaler boundary when the peripheral tick follows the system tick. The bench makes these collisions happen. It drives dense random strobes and writes random divider codes, valid and reserved, so writes often hit the boundary cycle. It also runs directed /16-to-/2 changes in the middle of a period. A bench model checks the result: on each edge it first advances both divider counters using the ratio that was pending before the edge, and only then applies the write. So a write on the boundary edge must still run one full period at the earlier ratio.

// File: rtl/clkgear_pkg.sv
package clkgear_pkg;
  localparam int REG_AW        = 1;
  localparam int REG_DW        = 8;
  localparam int CODE_W        = 3;
  localparam int GEAR_MAX_LOG  = 4;
  localparam int PRESC_MAX_LOG = 5;

  localparam logic [REG_AW-1:0] ADDR_SRC = 1'b0;
  localparam logic [REG_AW-1:0] ADDR_DIV = 1'b1;

  // source register bit positions
  localparam int B_OSC_SEL = 0;
  localparam int B_PLL_SEL = 1;
  localparam int B_PLL_EN  = 2;
  localparam int B_EXT_EN  = 3;
  localparam int B_LO_EN   = 4;
  // divider register field positions
  localparam int F_GEAR_LO  = 0;
  localparam int B_PSRC     = 3;
  localparam int F_PRESC_LO = 4;

  typedef struct packed {
    logic lo_en;
    logic ext_en;
    logic pll_en;
    logic pll_sel;
    logic osc_sel;
  } src_cfg_t;

  typedef enum logic {PSRC_GEAR = 1'b0, PSRC_FC = 1'b1} psrc_e;

  function automatic logic code_ok(input logic [CODE_W-1:0] code, input int max_log);
    return int'(code) <= max_log;
  endfunction
endpackage

// File: rtl/clkgear_regs.sv
module clkgear_regs
  import clkgear_pkg::*;
#(
  parameter int GEAR_MAX  = GEAR_MAX_LOG,
  parameter int PRESC_MAX = PRESC_MAX_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output src_cfg_t          src_cfg,
  output logic [CODE_W-1:0] gear_pend,
  output logic [CODE_W-1:0] presc_pend,
  output psrc_e             psrc,
  output logic              pll_err
);
  logic [CODE_W-1:0] gear_field;
  logic [CODE_W-1:0] presc_field;
  logic              bad_pll_req;

  always_comb begin
    gear_field  = wr_data[F_GEAR_LO +: CODE_W];
    presc_field = wr_data[F_PRESC_LO +: CODE_W];
    bad_pll_req = wr_data[B_PLL_SEL] & ~wr_data[B_PLL_EN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_cfg    <= '0;
      gear_pend  <= '0;
      presc_pend <= '0;
      psrc       <= PSRC_GEAR;
      pll_err    <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_SRC) begin
        src_cfg.osc_sel <= wr_data[B_OSC_SEL];
        src_cfg.pll_sel <= wr_data[B_PLL_SEL];
        src_cfg.pll_en  <= wr_data[B_PLL_EN];
        src_cfg.ext_en  <= wr_data[B_EXT_EN];
        src_cfg.lo_en   <= wr_data[B_LO_EN];
        if (bad_pll_req) pll_err <= 1'b1;
      end else begin
        if (code_ok(gear_field, GEAR_MAX))   gear_pend  <= gear_field;
        if (code_ok(presc_field, PRESC_MAX)) presc_pend <= presc_field;
        psrc <= psrc_e'(wr_data[B_PSRC]);
      end
    end
  end
endmodule

// File: rtl/clkgear_src.sv
module clkgear_src
  import clkgear_pkg::*;
(
  input  src_cfg_t cfg,
  input  logic     int_tick,
  input  logic     ext_tick,
  input  logic     pll_tick,
  output logic     hs_tick
);
  logic fosc_tick;
  logic use_pll;

  always_comb begin
    fosc_tick = cfg.osc_sel ? ext_tick : int_tick;
    use_pll   = cfg.pll_sel & cfg.pll_en;
    hs_tick   = use_pll ? pll_tick : fosc_tick;
  end
endmodule

// File: rtl/clkgear_div.sv
module clkgear_div #(
  parameter int MAX_LOG = 4,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic [CODE_W-1:0] code_pend,
  output logic              tick_out
);
  localparam int CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] act;
  logic [CNT_W-1:0]  last;
  logic              wrap;

  always_comb begin
    last     = ~({CNT_W{1'b1}} << act);
    wrap     = (cnt == last);
    tick_out = tick_in & wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= '0;
    end else if (tick_in) begin
      if (wrap) begin
        cnt <= '0;
        act <= code_pend;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkgear_ctrl.sv
module clkgear_ctrl
  import clkgear_pkg::*;
#(
  parameter int GEAR_MAX  = GEAR_MAX_LOG,
  parameter int PRESC_MAX = PRESC_MAX_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_tick,
  input  logic              ext_tick,
  input  logic              pll_tick,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic              hs_tick,
  output logic              sys_tick,
  output logic              periph_tick,
  output logic              presc_tick,
  output logic              ext_hs_on,
  output logic              lo_on,
  output logic              pll_on,
  output logic              pll_err
);
  src_cfg_t          cfg;
  logic [CODE_W-1:0] gear_pend;
  logic [CODE_W-1:0] presc_pend;
  psrc_e             psrc;

  clkgear_regs #(.GEAR_MAX(GEAR_MAX), .PRESC_MAX(PRESC_MAX)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_cfg(cfg), .gear_pend(gear_pend), .presc_pend(presc_pend),
    .psrc(psrc), .pll_err(pll_err)
  );

  clkgear_src u_src (
    .cfg(cfg), .int_tick(int_tick), .ext_tick(ext_tick), .pll_tick(pll_tick),
    .hs_tick(hs_tick)
  );

  clkgear_div #(.MAX_LOG(GEAR_MAX), .CODE_W(CODE_W)) u_gear (
    .clk(clk), .rst_n(rst_n), .tick_in(hs_tick), .code_pend(gear_pend),
    .tick_out(sys_tick)
  );

  always_comb periph_tick = (psrc == PSRC_FC) ? hs_tick : sys_tick;

  clkgear_div #(.MAX_LOG(PRESC_MAX), .CODE_W(CODE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_in(periph_tick), .code_pend(presc_pend),
    .tick_out(presc_tick)
  );

  always_comb begin
    ext_hs_on = cfg.ext_en;
    lo_on     = cfg.lo_en;
    pll_on    = cfg.pll_en;
  end
endmodule

// File: rtl/clkgear_ctrl_chk.sv
module clkgear_ctrl_chk #(
  parameter int GEAR_MAX = 4
) (
  input logic clk,
  input logic rst_n,
  input logic int_tick,
  input logic ext_tick,
  input logic pll_tick,
  input logic hs_tick,
  input logic sys_tick,
  input logic periph_tick,
  input logic presc_tick,
  input logic pll_on,
  input logic pll_err,
  input logic ext_hs_on,
  input logic lo_on
);
  localparam int GLAST = (1 << GEAR_MAX) - 1;
  localparam int GW    = GEAR_MAX + 1;

  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (sys_tick) gap <= '0;
    else if (hs_tick) gap <= gap + 1'b1;
  end

  a_r1_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pll_err && !pll_on && !ext_hs_on && !lo_on));
  a_r3_pll_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_tick && !pll_on) |-> (int_tick || ext_tick));
  a_r3_hs_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    hs_tick |-> (int_tick || ext_tick || pll_tick));
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pll_err |=> pll_err);
  a_r5_sys_on_hs: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |-> hs_tick);
  a_r5_max_period: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_tick && (int'(gap) == GLAST)) |-> sys_tick);
  a_r7_periph_on_hs: assert property (@(posedge clk) disable iff (!rst_n)
    periph_tick |-> hs_tick);
  a_r8_presc_on_periph: assert property (@(posedge clk) disable iff (!rst_n)
    presc_tick |-> periph_tick);
endmodule

bind clkgear_ctrl clkgear_ctrl_chk #(.GEAR_MAX(GEAR_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_tick(ext_tick),
  .pll_tick(pll_tick), .hs_tick(hs_tick), .sys_tick(sys_tick),
  .periph_tick(periph_tick), .presc_tick(presc_tick), .pll_on(pll_on),
  .pll_err(pll_err), .ext_hs_on(ext_hs_on), .lo_on(lo_on)
);

// File: tb/clkgear_ctrl_bench.sv
module clkgear_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       int_tick = 1'b0, ext_tick = 1'b0, pll_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       hs_tick, sys_tick, periph_tick, presc_tick;
  logic       ext_hs_on, lo_on, pll_on, pll_err;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // bench model state
  bit m_osc, m_psel, m_pen, m_exten, m_loen, m_err, m_psrc;
  int m_gpend, m_gact, m_gcnt, m_ppend, m_pact, m_pcnt;

  always #4 clk = ~clk;

  clkgear_ctrl u_clkgear_ctrl (
    .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_tick(ext_tick),
    .pll_tick(pll_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hs_tick(hs_tick), .sys_tick(sys_tick), .periph_tick(periph_tick),
    .presc_tick(presc_tick), .ext_hs_on(ext_hs_on), .lo_on(lo_on),
    .pll_on(pll_on), .pll_err(pll_err)
  );

  function automatic bit at_end(int cnt, int shift);
    return cnt == (1 << shift) - 1;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s): actual %b expected %b at %0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_osc = 0; m_psel = 0; m_pen = 0; m_exten = 0; m_loen = 0; m_err = 0; m_psrc = 0;
    m_gpend = 0; m_gact = 0; m_gcnt = 0; m_ppend = 0; m_pact = 0; m_pcnt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; int_tick = 0; ext_tick = 0; pll_tick = 0; wr_en = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(bit it, bit et, bit pt, bit we, bit wa, bit [7:0] wd);
    bit e_hs, e_sys, e_per, e_pre, fosc;
    @(negedge clk);
    int_tick = it; ext_tick = et; pll_tick = pt;
    wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    fosc  = m_osc ? et : it;
    e_hs  = (m_psel && m_pen) ? pt : fosc;
    e_sys = e_hs && at_end(m_gcnt, m_gact);
    e_per = m_psrc ? e_hs : e_sys;
    e_pre = e_per && at_end(m_pcnt, m_pact);
    chk("R3 hs_tick", hs_tick, e_hs);
    chk("R5 sys_tick", sys_tick, e_sys);
    chk("R7 periph_tick", periph_tick, e_per);
    chk("R8 presc_tick", presc_tick, e_pre);
    chk("R4 pll_err", pll_err, m_err);
    chk("R10 ext_hs_on", ext_hs_on, m_exten);
    chk("R10 lo_on", lo_on, m_loen);
    chk("R10 pll_on", pll_on, m_pen);
    // divider counters advance with the ratio pending before this edge
    if (e_hs) begin
      if (at_end(m_gcnt, m_gact)) begin m_gcnt = 0; m_gact = m_gpend; end
      else m_gcnt++;
    end
    if (e_per) begin
      if (at_end(m_pcnt, m_pact)) begin m_pcnt = 0; m_pact = m_ppend; end
      else m_pcnt++;
    end
    if (we) begin
      if (!wa) begin
        m_osc = wd[0]; m_psel = wd[1]; m_pen = wd[2]; m_exten = wd[3]; m_loen = wd[4];
        if (wd[1] && !wd[2]) m_err = 1;
      end else begin
        if (wd[2:0] <= 3'd4) m_gpend = int'(wd[2:0]);
        if (wd[6:4] <= 3'd5) m_ppend = int'(wd[6:4]);
        m_psrc = wd[3];
      end
    end
  endtask

  task automatic ticks(int n, bit it, bit et, bit pt);
    for (int i = 0; i < n; i++) step(it, et, pt, 0, 0, 8'h00);
  endtask

  task automatic wr(bit wa, bit [7:0] wd);
    step(0, 0, 0, 1, wa, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    do_reset();
    // R1: reset state and undivided internal path
    phase = "R1";
    #1;
    chk("R1 pll_err after reset", pll_err, 1'b0);
    chk("R1 pll_on after reset", pll_on, 1'b0);
    step(1, 0, 0, 0, 0, 8'h00);
    step(0, 1, 1, 0, 0, 8'h00);
    ticks(4, 1, 0, 0);
    // R2: external oscillator select, with its run flag
    phase = "R2";
    wr(0, 8'h09);
    ticks(3, 0, 1, 0);
    ticks(3, 1, 0, 0);
    wr(0, 8'h10);
    ticks(3, 1, 1, 0);
    // R9: mid-period ratio change
    phase = "R9";
    wr(1, 8'h04);
    ticks(2, 1, 0, 0);
    ticks(5, 1, 0, 0);
    wr(1, 8'h01);
    ticks(20, 1, 0, 0);
    // R6: reserved gear codes hold the ratio, other fields still apply
    phase = "R6";
    wr(1, 8'h03);
    ticks(9, 1, 0, 0);
    wr(1, 8'h1D);
    ticks(24, 1, 0, 0);
    wr(1, 8'h07);
    ticks(24, 1, 0, 0);
    // R8: prescaler on direct peripheral source, reserved prescaler codes
    phase = "R8";
    wr(1, 8'h58);
    ticks(70, 1, 0, 0);
    wr(1, 8'h78);
    ticks(70, 1, 0, 0);
    wr(1, 8'h28);
    ticks(20, 1, 0, 0);
    // R4: refused PLL request, then sticky flag
    phase = "R4";
    wr(0, 8'h02);
    ticks(3, 0, 0, 1);
    ticks(3, 1, 0, 1);
    // R3: PLL path once marked running
    phase = "R3";
    wr(0, 8'h06);
    ticks(4, 0, 0, 1);
    ticks(4, 1, 1, 0);
    wr(0, 8'h00);
    ticks(2, 1, 0, 0);
    // R1: reset clears sticky error and ratios
    phase = "R1";
    do_reset();
    ticks(4, 1, 0, 0);
    // R5: random mix with dense strobes and random writes
    phase = "R5";
    for (int i = 0; i < 4000; i++) begin
      bit we;
      we = ($urandom % 7) == 0;
      step($urandom % 2, $urandom % 2, $urandom % 2, we, $urandom % 2, 8'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule